// File: doc/BRIEF.md
# ECC Error Record Correction Unit

This unit walks through the stream of ECC error records that a flash channel reports after a page read and repairs the page image held in a local byte-wide buffer RAM. Each record names the page it belongs to, the ECC sector within that page, the byte offset inside the sector, the index of the flash device that held the bad byte, and an XOR mask. A type bit marks the error as uncorrectable.

For a correctable record with an offset inside the ECC sector, the unit works out where the byte sits in the buffer. Several devices may be connected side by side, so their bytes are interleaved in the buffer. The unit then reads that byte, XORs it with the mask and writes it back. An uncorrectable record touches no memory and only raises the event. Records are taken one by one until a record with the last bit arrives. The unit then pulses `done`, and `event_code` holds the result for the whole run of records.

The buffer RAM is outside the unit and has a read latency of one cycle: data for a read issued in one cycle is on `ram_rdata` in the next cycle.

Top module: `ecc_fix_unit`

## Requirements
- R1: Record fields: `rec_err_addr[11:0]` is the byte offset and `rec_err_addr[15:12]` is the sector number. In `rec_corr_info`, bits 7:0 are the XOR mask, bits 13:8 the device index, bit 14 the error type (1 = uncorrectable) and bit 15 the last-record flag.
- R2: The buffer address is (page − cfg_start_page) × cfg_page_size + sector × ECC_SECT × cfg_devices + offset × cfg_devices + device, truncated to ADDR_W bits.
- R3: For a correctable record with offset < ECC_SECT, the unit issues a read of the computed address in the cycle after acceptance. In the cycle after that it writes the read byte XOR the mask to the same address.
- R4: An uncorrectable record causes no RAM read or write.
- R5: A correctable record with offset ≥ ECC_SECT causes no RAM access, yet it still counts as correctable.
- R6: While a read-modify-write is in progress, `rec_ready` is low for exactly two cycles and then returns high.
- R7: `done` is a one-cycle pulse for the record with the last flag. It comes in the cycle after acceptance when no RAM access is made, or in the cycle after the write otherwise.
- R8: `event_code` is 0 for none, 1 for correctable-fixed and 2 for uncorrectable. Within one run of records an uncorrectable record keeps the code at 2. The first record of a new run starts from none.
- R9: After reset, `rec_ready` is high, and `done`, `event_code`, `ram_rd_en` and `ram_wr_en` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rec_valid | input | 1 | Error record present |
| rec_ready | output | 1 | Unit can take a record |
| rec_page | input | PAGE_W | Page the error belongs to |
| rec_err_addr | input | 16 | Offset and sector word |
| rec_corr_info | input | 16 | Mask, device, type and last word |
| cfg_page_size | input | ADDR_W+1 | Bytes per page in the buffer |
| cfg_devices | input | DEVN_W | Number of connected devices (1 or more) |
| cfg_start_page | input | PAGE_W | Page held at buffer address 0 |
| ram_addr | output | ADDR_W | Buffer byte address |
| ram_rd_en | output | 1 | Buffer read strobe |
| ram_rdata | input | 8 | Read data, one cycle after the strobe |
| ram_wr_en | output | 1 | Buffer write strobe |
| ram_wdata | output | 8 | Corrected byte |
| done | output | 1 | Last record finished |
| event_code | output | 2 | Result of the current run of records |

## Verification
The assertions take for granted that the configuration inputs stay stable while a run of records is in progress. They also assume `cfg_devices` is never zero and that the RAM returns read data exactly one cycle after the strobe. The stimulus changes the configuration only between runs, and only after `done` has been seen. It always uses one to four devices. Its RAM model registers read data on the edge that follows the strobe.

// File: rtl/ecc_fix_pkg.sv
// Shared field positions and types for the ECC error record correction unit.
// Assumes 16-bit record words; the offset/sector and mask/device positions
// are fixed by the producer of the records.
package ecc_fix_pkg;
    localparam int WORD_W   = 16;
    localparam int OFF_LSB  = 0;
    localparam int OFF_W    = 12;
    localparam int SEC_LSB  = 12;
    localparam int SEC_W    = 4;
    localparam int MASK_LSB = 0;
    localparam int MASK_W   = 8;
    localparam int DEVF_LSB = 8;
    localparam int DEVF_W   = 6;
    localparam int UNC_BIT  = 14;
    localparam int LAST_BIT = 15;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_CORR   = 2'd1,
        EV_UNCORR = 2'd2
    } ecc_event_e;

    typedef struct packed {
        logic [OFF_W-1:0]  offset;
        logic [SEC_W-1:0]  sector;
        logic [MASK_W-1:0] mask;
        logic [DEVF_W-1:0] device;
        logic              uncorr;
        logic              last;
    } err_rec_t;
endpackage

// File: rtl/ecc_rec_decode.sv
// Splits the two record words into fields and classifies the record.
// Assumes: words are valid whenever the caller samples the result.
module ecc_rec_decode
    import ecc_fix_pkg::*;
#(
    parameter int unsigned ECC_SECT = 512
) (
    input  logic [WORD_W-1:0] err_addr,
    input  logic [WORD_W-1:0] corr_info,
    output err_rec_t          rec,
    output logic              in_range,
    output logic              need_fix
);
    // Field extraction from the two words.
    always_comb begin
        rec.offset = err_addr[OFF_LSB +: OFF_W];
        rec.sector = err_addr[SEC_LSB +: SEC_W];
        rec.mask   = corr_info[MASK_LSB +: MASK_W];
        rec.device = corr_info[DEVF_LSB +: DEVF_W];
        rec.uncorr = corr_info[UNC_BIT];
        rec.last   = corr_info[LAST_BIT];
    end

    // Offset inside the ECC sector, and whether a memory update is due.
    always_comb begin
        in_range = 32'(rec.offset) < ECC_SECT;
        need_fix = !rec.uncorr && in_range;
    end
endmodule

// File: rtl/ecc_addr_calc.sv
// Computes the buffer byte address of a bad byte, with the bytes of the
// connected devices interleaved. Purely combinational.
// Assumes: devices >= 1, start_page <= page (the difference wraps otherwise).
module ecc_addr_calc
    import ecc_fix_pkg::*;
#(
    parameter int          ADDR_W   = 14,
    parameter int          PAGE_W   = 8,
    parameter int          DEVN_W   = 3,
    parameter int unsigned ECC_SECT = 512
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [PAGE_W-1:0] start_page,
    input  logic [ADDR_W:0]   page_size,
    input  logic [DEVN_W-1:0] devices,
    input  logic [SEC_W-1:0]  sector,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DEVF_W-1:0] device,
    output logic [ADDR_W-1:0] byte_addr
);
    localparam int CALC_W = 32;

    logic [PAGE_W-1:0] page_delta;
    logic [CALC_W-1:0] eff_sect;
    logic [CALC_W-1:0] page_base;
    logic [CALC_W-1:0] sect_base;
    logic [CALC_W-1:0] byte_pos;

    // Relative page, effective sector size and partial offsets.
    always_comb begin
        page_delta = page - start_page;
        eff_sect   = CALC_W'(ECC_SECT) * CALC_W'(devices);
        page_base  = CALC_W'(page_delta) * CALC_W'(page_size);
        sect_base  = CALC_W'(sector) * eff_sect;
        byte_pos   = CALC_W'(offset) * CALC_W'(devices) + CALC_W'(device);
    end

    assign byte_addr = ADDR_W'(page_base + sect_base + byte_pos);
endmodule

// File: rtl/ecc_event_track.sv
// Keeps the event code of the current run of records. Uncorrectable wins
// over correctable; the first record after a last record starts afresh.
// Assumes: accept is a single-cycle handshake strobe.
module ecc_event_track
    import ecc_fix_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic       rec_uncorr,
    input  logic       rec_last,
    output ecc_event_e event_q
);
    logic       seq_open;
    ecc_event_e base_ev;
    ecc_event_e next_ev;

    // Merge the new record into the running code.
    always_comb begin
        base_ev = seq_open ? event_q : EV_NONE;
        if (rec_uncorr || base_ev == EV_UNCORR) begin
            next_ev = EV_UNCORR;
        end else begin
            next_ev = EV_CORR;
        end
    end

    // Register the code and whether a run is still open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            event_q  <= EV_NONE;
            seq_open <= 1'b0;
        end else if (accept) begin
            event_q  <= next_ev;
            seq_open <= !rec_last;
        end
    end

    AST_UNCORR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_open && event_q == EV_UNCORR) |=> (event_q == EV_UNCORR)); // R8
endmodule

// File: rtl/ecc_rmw_ctrl.sv
// Sequencer for the read-modify-write of one buffer byte and the done pulse.
// Assumes: RAM read data arrives one cycle after ram_rd_en.
module ecc_rmw_ctrl
    import ecc_fix_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    output logic              rec_ready,
    input  logic              need_fix,
    input  logic              is_last,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [MASK_W-1:0] mask,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_rd_en,
    input  logic [7:0]        ram_rdata,
    output logic              ram_wr_en,
    output logic [7:0]        ram_wdata,
    output logic              done
);
    typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} rmw_state_e;

    rmw_state_e        state;
    logic [ADDR_W-1:0] addr_q;
    logic [MASK_W-1:0] mask_q;
    logic              last_q;
    logic              done_q;
    logic              accept;

    assign rec_ready = (state == S_IDLE);
    assign accept    = rec_valid && rec_ready;

    // State walk: idle -> read -> write -> idle; done on the last record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            addr_q <= '0;
            mask_q <= '0;
            last_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (accept) begin
                        if (need_fix) begin
                            state  <= S_READ;
                            addr_q <= byte_addr;
                            mask_q <= mask;
                            last_q <= is_last;
                        end else begin
                            done_q <= is_last;
                        end
                    end
                end
                S_READ:  state <= S_WRITE;
                S_WRITE: begin
                    state  <= S_IDLE;
                    done_q <= last_q;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // RAM strobes and corrected data.
    always_comb begin
        ram_rd_en = (state == S_READ);
        ram_wr_en = (state == S_WRITE);
        ram_addr  = addr_q;
        ram_wdata = ram_rdata ^ mask_q;
    end

    assign done = done_q;

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_en |-> ($past(ram_rd_en) && ram_addr == $past(ram_addr))); // R3
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en |=> ram_wr_en); // R3
    AST_READ_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_rd_en) |-> $past(rec_valid && rec_ready)); // R6
    AST_READY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_en |=> rec_ready); // R6
    AST_DONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(ram_wr_en) || $past(rec_valid && rec_ready))); // R7
endmodule

// File: rtl/ecc_fix_unit.sv
// Top of the ECC error record correction unit: decodes records, computes
// the interleaved buffer address, repairs correctable bytes by
// read-modify-write and reports the run's event code with a done pulse.
// Assumes: configuration is stable during a run, cfg_devices >= 1.
module ecc_fix_unit
    import ecc_fix_pkg::*;
#(
    parameter int          ADDR_W   = 14,
    parameter int          PAGE_W   = 8,
    parameter int          DEVN_W   = 3,
    parameter int unsigned ECC_SECT = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    output logic              rec_ready,
    input  logic [PAGE_W-1:0] rec_page,
    input  logic [15:0]       rec_err_addr,
    input  logic [15:0]       rec_corr_info,
    input  logic [ADDR_W:0]   cfg_page_size,
    input  logic [DEVN_W-1:0] cfg_devices,
    input  logic [PAGE_W-1:0] cfg_start_page,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_rd_en,
    input  logic [7:0]        ram_rdata,
    output logic              ram_wr_en,
    output logic [7:0]        ram_wdata,
    output logic              done,
    output logic [1:0]        event_code
);
    err_rec_t          rec;
    logic              in_range;
    logic              need_fix;
    logic [ADDR_W-1:0] byte_addr;
    logic              accept;
    ecc_event_e        event_q;

    assign accept     = rec_valid && rec_ready;
    assign event_code = event_q;

    ecc_rec_decode #(.ECC_SECT(ECC_SECT)) u_decode (
        .err_addr  (rec_err_addr),
        .corr_info (rec_corr_info),
        .rec       (rec),
        .in_range  (in_range),
        .need_fix  (need_fix)
    );

    ecc_addr_calc #(
        .ADDR_W   (ADDR_W),
        .PAGE_W   (PAGE_W),
        .DEVN_W   (DEVN_W),
        .ECC_SECT (ECC_SECT)
    ) u_addr (
        .page       (rec_page),
        .start_page (cfg_start_page),
        .page_size  (cfg_page_size),
        .devices    (cfg_devices),
        .sector     (rec.sector),
        .offset     (rec.offset),
        .device     (rec.device),
        .byte_addr  (byte_addr)
    );

    ecc_rmw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_valid (rec_valid),
        .rec_ready (rec_ready),
        .need_fix  (need_fix),
        .is_last   (rec.last),
        .byte_addr (byte_addr),
        .mask      (rec.mask),
        .ram_addr  (ram_addr),
        .ram_rd_en (ram_rd_en),
        .ram_rdata (ram_rdata),
        .ram_wr_en (ram_wr_en),
        .ram_wdata (ram_wdata),
        .done      (done)
    );

    ecc_event_track u_event (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .rec_uncorr (rec.uncorr),
        .rec_last   (rec.last),
        .event_q    (event_q)
    );

    AST_UNCORR_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && rec_corr_info[UNC_BIT]) |=> !ram_rd_en); // R4
    AST_OUT_OF_RANGE_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && 32'(rec_err_addr[OFF_W-1:0]) >= ECC_SECT) |=> !ram_rd_en); // R5
    AST_EVENT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (event_code != 2'd0)); // R8
endmodule

// File: tb/ecc_fix_unit_tb_top.sv
module ecc_fix_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 14;
    localparam int PW   = 8;
    localparam int DW   = 3;
    localparam int SECT = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rec_valid = 1'b0;
    logic          rec_ready;
    logic [PW-1:0] rec_page = '0;
    logic [15:0]   rec_err_addr = '0;
    logic [15:0]   rec_corr_info = '0;
    logic [AW:0]   cfg_page_size = 15'd2048;
    logic [DW-1:0] cfg_devices = 3'd1;
    logic [PW-1:0] cfg_start_page = '0;
    logic [AW-1:0] ram_addr;
    logic          ram_rd_en;
    logic [7:0]    ram_rdata = '0;
    logic          ram_wr_en;
    logic [7:0]    ram_wdata;
    logic          done;
    logic [1:0]    event_code;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    logic [7:0] ram_mem [int];
    logic [7:0] shadow  [int];
    int   exp_waddr [$];
    int   exp_wdata [$];
    int   exp_event [$];
    int   seq_ev = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_fix_unit dut_i (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_page(rec_page), .rec_err_addr(rec_err_addr), .rec_corr_info(rec_corr_info),
        .cfg_page_size(cfg_page_size), .cfg_devices(cfg_devices),
        .cfg_start_page(cfg_start_page), .ram_addr(ram_addr), .ram_rd_en(ram_rd_en),
        .ram_rdata(ram_rdata), .ram_wr_en(ram_wr_en), .ram_wdata(ram_wdata),
        .done(done), .event_code(event_code)
    );

    function automatic logic [7:0] init_byte(int a);
        return 8'(a * 37 + 11);
    endfunction

    // RAM model with one-cycle read latency.
    always @(posedge clk) begin
        if (ram_rd_en)
            ram_rdata <= ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)]
                                                        : init_byte(int'(ram_addr));
        if (ram_wr_en) ram_mem[int'(ram_addr)] = ram_wdata;
    end

    task automatic check(string req, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // Monitor: pops expected writes and done events as they appear.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (ram_wr_en) begin
                if (exp_waddr.size() == 0) begin
                    check("R4/R5 unexpected write", 1, 0);
                end else begin
                    check("R2 write address", int'(ram_addr), exp_waddr.pop_front());
                    check("R3 write data", int'(ram_wdata), exp_wdata.pop_front());
                end
            end
            if (done) begin
                if (exp_event.size() == 0) check("R7 unexpected done", 1, 0);
                else check("R8 event at done", int'(event_code), exp_event.pop_front());
            end
        end
    end

    // Driver: computes expectations (R1, R2) and sends one record.
    task automatic send(int pg, int sec, int off, int dev, int mask, bit unc, bit last);
        int a;
        bit fix;
        fix = !unc && (off < SECT);
        a = ((pg - int'(cfg_start_page)) * int'(cfg_page_size)
             + sec * SECT * int'(cfg_devices) + off * int'(cfg_devices) + dev)
            & ((1 << AW) - 1);
        if (unc) seq_ev = 2;
        else if (seq_ev != 2) seq_ev = 1;
        if (fix) begin
            logic [7:0] old;
            old = shadow.exists(a) ? shadow[a] : init_byte(a);
            shadow[a] = old ^ 8'(mask);
            exp_waddr.push_back(a);
            exp_wdata.push_back(int'(old ^ 8'(mask)));
        end
        if (last) begin
            exp_event.push_back(seq_ev);
            seq_ev = 0;
        end
        @(negedge clk);
        rec_valid     = 1'b1;
        rec_page      = PW'(pg);
        rec_err_addr  = {4'(sec), 12'(off)};
        rec_corr_info = {last, unc, 6'(dev), 8'(mask)};
        while (!rec_ready) @(negedge clk);
        @(posedge clk);
        #1 rec_valid = 1'b0;
        if (fix) begin
            @(negedge clk); check("R6 ready low in read", int'(rec_ready), 0);
            @(negedge clk); check("R6 ready low in write", int'(rec_ready), 0);
            @(negedge clk); check("R6 ready back", int'(rec_ready), 1);
        end
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R9 ready after reset", int'(rec_ready), 1);
        check("R9 done after reset", int'(done), 0);
        check("R9 event after reset", int'(event_code), 0);
        check("R9 strobes after reset", int'(ram_rd_en | ram_wr_en), 0);

        // R1 R2 R3: one device, two fixes, correctable.
        cfg_start_page = 8'd5;
        send(5, 0, 3, 0, 8'h5A, 0, 0);
        send(6, 2, 100, 0, 8'h81, 0, 1);
        drain();

        // R2: two devices interleaved, offset at the sector edge.
        cfg_devices = 3'd2; cfg_start_page = 8'd10;
        send(10, 1, 7, 1, 8'h0F, 0, 0);
        send(11, 0, SECT - 1, 0, 8'hF0, 0, 1);
        drain();

        // R5: offset past the sector is skipped but correctable.
        send(10, 0, SECT, 1, 8'hFF, 0, 0);
        send(10, 3, 20, 0, 8'h33, 0, 1);
        drain();

        // R4 R8: uncorrectable first, later fix still written, event stays 2.
        send(12, 1, 9, 1, 8'hAA, 1, 0);
        send(12, 1, 9, 0, 8'h44, 0, 1);
        drain();

        // R4 R7: single uncorrectable last record.
        send(13, 0, 0, 0, 8'h11, 1, 1);
        drain();

        // R7 R8: back-to-back skipped last records start fresh after an uncorrectable run.
        send(13, 0, SECT + 5, 0, 8'h01, 0, 1);
        send(13, 0, 4095, 1, 8'h02, 0, 1);
        drain();

        // R2: four devices, top device index.
        cfg_devices = 3'd4; cfg_start_page = 8'd0;
        send(1, 3, 10, 3, 8'h77, 0, 1);
        drain();

        check("R7 all done events seen", exp_event.size(), 0);
        check("R3 all writes seen", exp_waddr.size(), 0);
        finished = 1;
        summary();
    end
endmodule